// File: doc/BRIEF.md
# Integer Execute Unit with Trapping Arithmetic

This block is the integer execute stage of a 32-bit load/store datapath. Each cycle it takes two register operands, a 16-bit instruction immediate, a destination register index and an operation code. It computes the result in one combinational pass and registers it, together with a write strobe for the register file and an overflow trap flag. Trap handling is left to the surrounding control logic.

The operation set covers arithmetic in two forms. The trapping form signals signed overflow. The wrapping form never does. It also covers the bitwise functions, signed and unsigned set-less-than, and the immediate variants of these, each extended as its kind requires. A trapping operation that overflows raises the flag and withholds the register write. A write aimed at register 0 is always withheld, so that register stays zero.

Top module: `exu_alu`

## Requirements
- R1: While rst_ni is low, result_o, wr_en_o, wr_dst_o and ovf_o are all zero.
- R2: Outputs are registered: inputs applied before a rising clock edge show at the outputs right after that edge and not earlier.
- R3: Trapping add (code 0), trapping subtract (code 2) and trapping add-immediate (code 10) set ovf_o to 1 and wr_en_o to 0 when the exact signed result does not fit in 32 bits.
- R4: Wrapping add (1), wrapping subtract (3) and wrapping add-immediate (11) return the sum or difference modulo 2^32, and ovf_o is 0 for every operation other than codes 0, 2 and 10.
- R5: AND (4), OR (5), XOR (6) and NOR (7) apply the bitwise function to a_i and b_i. NOR returns ~(a_i | b_i).
- R6: Set-less-than signed (8) and unsigned (9) return 1 when a_i < b_i and 0 otherwise, using a two's-complement compare for code 8 and an unsigned compare for code 9.
- R7: Codes 10, 11 and 12 (set-less-than-immediate, signed compare) use imm_i sign-extended to 32 bits in place of b_i.
- R8: Code 13 sign-extends imm_i to 32 bits, then compares it with a_i as unsigned and returns 1 or 0.
- R9: AND-, OR- and XOR-immediate (14, 15, 16) use imm_i zero-extended to 32 bits.
- R10: Load-upper (17) returns imm_i in bits 31:16 with bits 15:0 cleared.
- R11: wr_en_o is 0 whenever dst_i is 0. Otherwise it is 1 for every defined code unless R3 withholds it.
- R12: Codes 18 to 31 are undefined: result_o is 0 and wr_en_o and ovf_o are 0.
- R13: wr_dst_o carries the dst_i presented before the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First register operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Instruction immediate |
| dst_i | input | 5 | Destination register index |
| result_o | output | 32 | Registered result |
| wr_en_o | output | 1 | Register file write strobe |
| wr_dst_o | output | 5 | Registered destination index |
| ovf_o | output | 1 | Overflow trap flag |

## Verification
Every output is due exactly one clock edge after its operands: the result, the write strobe, the destination and the trap flag all pass through a single register stage. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. One directed check also samples just before that edge, to confirm the previous values still stand. Random operations are mixed with directed overflow boundaries, extension corners, register-0 destinations and undefined codes, all compared against a 64-bit reference model written in the bench.

// File: rtl/exu_alu_pkg.sv
package exu_alu_pkg;

  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 5'd0,
    OP_ADDU  = 5'd1,
    OP_SUB   = 5'd2,
    OP_SUBU  = 5'd3,
    OP_AND   = 5'd4,
    OP_OR    = 5'd5,
    OP_XOR   = 5'd6,
    OP_NOR   = 5'd7,
    OP_SLT   = 5'd8,
    OP_SLTU  = 5'd9,
    OP_ADDI  = 5'd10,
    OP_ADDIU = 5'd11,
    OP_SLTI  = 5'd12,
    OP_SLTIU = 5'd13,
    OP_ANDI  = 5'd14,
    OP_ORI   = 5'd15,
    OP_XORI  = 5'd16,
    OP_LUI   = 5'd17
  } alu_op_e;

  typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_UPPER} ext_e;
  typedef enum logic [1:0] {SEL_ARITH, SEL_LOGIC, SEL_CMP, SEL_PASSB} res_sel_e;
  typedef enum logic [1:0] {LG_AND, LG_OR, LG_XOR, LG_NOR} logic_fn_e;

  typedef struct packed {
    logic      legal;
    logic      use_imm;
    ext_e      ext;
    logic      sub;
    logic      trap;
    logic      cmp_signed;
    logic_fn_e lfn;
    res_sel_e  sel;
  } ctrl_t;

endpackage

// File: rtl/exu_alu_decode.sv
module exu_alu_decode
  import exu_alu_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctrl_t           ctrl_o
);

  always_comb begin
    ctrl_o = '{legal: 1'b1, use_imm: 1'b0, ext: EXT_SIGN, sub: 1'b0, trap: 1'b0,
               cmp_signed: 1'b0, lfn: LG_AND, sel: SEL_ARITH};
    unique case (op_i)
      OP_ADD:   ctrl_o.trap = 1'b1;
      OP_ADDU:  ;
      OP_SUB:   begin ctrl_o.sub = 1'b1; ctrl_o.trap = 1'b1; end
      OP_SUBU:  ctrl_o.sub = 1'b1;
      OP_AND:   begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_AND; end
      OP_OR:    begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_OR;  end
      OP_XOR:   begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_XOR; end
      OP_NOR:   begin ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_NOR; end
      OP_SLT:   begin ctrl_o.sel = SEL_CMP; ctrl_o.cmp_signed = 1'b1; end
      OP_SLTU:  ctrl_o.sel = SEL_CMP;
      OP_ADDI:  begin ctrl_o.use_imm = 1'b1; ctrl_o.trap = 1'b1; end
      OP_ADDIU: ctrl_o.use_imm = 1'b1;
      OP_SLTI:  begin
        ctrl_o.use_imm = 1'b1; ctrl_o.sel = SEL_CMP; ctrl_o.cmp_signed = 1'b1;
      end
      OP_SLTIU: begin ctrl_o.use_imm = 1'b1; ctrl_o.sel = SEL_CMP; end
      OP_ANDI:  begin
        ctrl_o.use_imm = 1'b1; ctrl_o.ext = EXT_ZERO; ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_AND;
      end
      OP_ORI:   begin
        ctrl_o.use_imm = 1'b1; ctrl_o.ext = EXT_ZERO; ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_OR;
      end
      OP_XORI:  begin
        ctrl_o.use_imm = 1'b1; ctrl_o.ext = EXT_ZERO; ctrl_o.sel = SEL_LOGIC; ctrl_o.lfn = LG_XOR;
      end
      OP_LUI:   begin ctrl_o.use_imm = 1'b1; ctrl_o.ext = EXT_UPPER; ctrl_o.sel = SEL_PASSB; end
      default:  ctrl_o.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/exu_alu_opb.sv
module exu_alu_opb
  import exu_alu_pkg::*;
#(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned IMM_W = 16
) (
  input  logic [XLEN-1:0]  b_i,
  input  logic [IMM_W-1:0] imm_i,
  input  logic             use_imm_i,
  input  ext_e             ext_i,
  output logic [XLEN-1:0]  opb_o
);

  localparam int unsigned PadW = XLEN - IMM_W;

  logic [XLEN-1:0] imm_sext, imm_zext, imm_upper;

  generate
    if (PadW > 0) begin : g_pad
      assign imm_sext  = {{PadW{imm_i[IMM_W-1]}}, imm_i};
      assign imm_zext  = {{PadW{1'b0}}, imm_i};
      assign imm_upper = {imm_i, {PadW{1'b0}}};
    end else begin : g_nopad
      assign imm_sext  = imm_i[XLEN-1:0];
      assign imm_zext  = imm_i[XLEN-1:0];
      assign imm_upper = imm_i[XLEN-1:0];
    end
  endgenerate

  always_comb begin
    if (!use_imm_i) opb_o = b_i;
    else begin
      unique case (ext_i)
        EXT_ZERO:  opb_o = imm_zext;
        EXT_UPPER: opb_o = imm_upper;
        default:   opb_o = imm_sext;
      endcase
    end
  end

endmodule

// File: rtl/exu_alu_addsub.sv
module exu_alu_addsub #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  output logic [XLEN-1:0] sum_o,
  output logic            ovf_o
);

  logic [XLEN-1:0] b_eff;
  logic            sa, sb, ss;

  assign b_eff = sub_i ? ~b_i : b_i;
  assign sum_o = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};

  // Overflow: effective operands share a sign that the result lacks
  assign sa    = a_i[XLEN-1];
  assign sb    = b_eff[XLEN-1];
  assign ss    = sum_o[XLEN-1];
  assign ovf_o = (sa == sb) && (ss != sa);

endmodule

// File: rtl/exu_alu_logic.sv
module exu_alu_logic
  import exu_alu_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic_fn_e       fn_i,
  output logic [XLEN-1:0] res_o
);

  always_comb begin
    unique case (fn_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      LG_XOR:  res_o = a_i ^ b_i;
      default: res_o = ~(a_i | b_i);
    endcase
  end

endmodule

// File: rtl/exu_alu_cmp.sv
module exu_alu_cmp #(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            signed_i,
  output logic            lt_o
);

  logic ult;

  assign ult = a_i < b_i;
  // Signed: differing signs decide directly, else the unsigned order holds
  assign lt_o = (signed_i && (a_i[XLEN-1] != b_i[XLEN-1])) ? a_i[XLEN-1] : ult;

endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_alu_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned REG_AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [OP_W-1:0]   op_i,
  input  logic [XLEN-1:0]   a_i,
  input  logic [XLEN-1:0]   b_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [REG_AW-1:0] dst_i,
  output logic [XLEN-1:0]   result_o,
  output logic              wr_en_o,
  output logic [REG_AW-1:0] wr_dst_o,
  output logic              ovf_o
);

  ctrl_t           ctrl;
  logic [XLEN-1:0] opb, sum, lres, res_d;
  logic            raw_ovf, lt, ovf_d, wr_d;

  exu_alu_decode i_decode (
    .op_i   (op_i),
    .ctrl_o (ctrl)
  );

  exu_alu_opb #(.XLEN(XLEN), .IMM_W(IMM_W)) i_opb (
    .b_i       (b_i),
    .imm_i     (imm_i),
    .use_imm_i (ctrl.use_imm),
    .ext_i     (ctrl.ext),
    .opb_o     (opb)
  );

  exu_alu_addsub #(.XLEN(XLEN)) i_addsub (
    .a_i   (a_i),
    .b_i   (opb),
    .sub_i (ctrl.sub),
    .sum_o (sum),
    .ovf_o (raw_ovf)
  );

  exu_alu_logic #(.XLEN(XLEN)) i_logic (
    .a_i   (a_i),
    .b_i   (opb),
    .fn_i  (ctrl.lfn),
    .res_o (lres)
  );

  exu_alu_cmp #(.XLEN(XLEN)) i_cmp (
    .a_i      (a_i),
    .b_i      (opb),
    .signed_i (ctrl.cmp_signed),
    .lt_o     (lt)
  );

  always_comb begin
    unique case (ctrl.sel)
      SEL_LOGIC: res_d = lres;
      SEL_CMP:   res_d = {{(XLEN-1){1'b0}}, lt};
      SEL_PASSB: res_d = opb;
      default:   res_d = sum;
    endcase
    if (!ctrl.legal) res_d = '0;
    ovf_d = ctrl.legal && ctrl.trap && raw_ovf;
    wr_d  = ctrl.legal && !ovf_d && (dst_i != '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      wr_en_o  <= 1'b0;
      wr_dst_o <= '0;
      ovf_o    <= 1'b0;
    end else begin
      result_o <= res_d;
      wr_en_o  <= wr_d;
      wr_dst_o <= dst_i;
      ovf_o    <= ovf_d;
    end
  end

endmodule

// File: rtl/exu_alu_chk.sv
module exu_alu_chk
  import exu_alu_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned REG_AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [OP_W-1:0]   op_i,
  input logic [REG_AW-1:0] dst_i,
  input logic [XLEN-1:0]   result_o,
  input logic              wr_en_o,
  input logic [REG_AW-1:0] wr_dst_o,
  input logic              ovf_o
);

  a_r3_trap_blocks_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> !wr_en_o);

  a_r11_zero_dst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_dst_o == '0) |-> !wr_en_o);

  a_r4_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !($past(op_i) inside {OP_ADD, OP_SUB, OP_ADDI})) |-> !ovf_o);

  a_r6_bool_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(op_i) inside {OP_SLT, OP_SLTU, OP_SLTI, OP_SLTIU}))
      |-> (result_o[XLEN-1:1] == '0));

  a_r10_upper_low_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(op_i) == OP_LUI)) |-> (result_o[XLEN-IMM_W-1:0] == '0));

  a_r12_undefined_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(op_i) > OP_LUI)) |-> (!wr_en_o && !ovf_o && result_o == '0));

  a_r13_dst_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (wr_dst_o == $past(dst_i)));

endmodule

bind exu_alu exu_alu_chk #(.XLEN(XLEN), .IMM_W(IMM_W), .REG_AW(REG_AW)) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .op_i     (op_i),
  .dst_i    (dst_i),
  .result_o (result_o),
  .wr_en_o  (wr_en_o),
  .wr_dst_o (wr_dst_o),
  .ovf_o    (ovf_o)
);

// File: tb/test_exu_alu.sv
`timescale 1ns/1ps
module test_exu_alu;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  op_i = '0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [15:0] imm_i = '0;
  logic [4:0]  dst_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o, ovf_o;
  logic [4:0]  wr_dst_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  exu_alu i_exu_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .a_i(a_i), .b_i(b_i),
    .imm_i(imm_i), .dst_i(dst_i), .result_o(result_o), .wr_en_o(wr_en_o),
    .wr_dst_o(wr_dst_o), .ovf_o(ovf_o)
  );

  function automatic string tag_of(input logic [4:0] op);
    case (op)
      5'd0, 5'd2:         return "R3";
      5'd1, 5'd3:         return "R4";
      5'd4, 5'd5, 5'd6, 5'd7: return "R5";
      5'd8, 5'd9:         return "R6";
      5'd10, 5'd11, 5'd12: return "R7";
      5'd13:              return "R8";
      5'd14, 5'd15, 5'd16: return "R9";
      5'd17:              return "R10";
      default:            return "R12";
    endcase
  endfunction

  // Reference model built from the requirements with 64-bit arithmetic
  function automatic void model(input logic [4:0] op, input logic [31:0] a, b,
                                input logic [15:0] imm, input logic [4:0] dst,
                                output logic [31:0] r, output logic we, output logic ov);
    logic [31:0] se, ze;
    longint sa, sb, s;
    bit legal;
    se = {{16{imm[15]}}, imm};
    ze = {16'h0, imm};
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    r = '0; ov = 0; legal = 1;
    case (op)
      5'd0: begin s = sa + sb; r = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      5'd1: r = a + b;
      5'd2: begin s = sa - sb; r = s[31:0]; ov = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      5'd3: r = a - b;
      5'd4: r = a & b;
      5'd5: r = a | b;
      5'd6: r = a ^ b;
      5'd7: r = ~(a | b);
      5'd8: r = {31'd0, $signed(a) < $signed(b)};
      5'd9: r = {31'd0, a < b};
      5'd10: begin
        s = sa + longint'($signed(se)); r = s[31:0];
        ov = (s > 64'sd2147483647) || (s < -64'sd2147483648);
      end
      5'd11: r = a + se;
      5'd12: r = {31'd0, $signed(a) < $signed(se)};
      5'd13: r = {31'd0, a < se};
      5'd14: r = a & ze;
      5'd15: r = a | ze;
      5'd16: r = a ^ ze;
      5'd17: r = {imm, 16'h0};
      default: legal = 0;
    endcase
    we = legal && !ov && (dst != 0);
  endfunction

  task automatic run_op(input logic [4:0] op, input logic [31:0] a, b,
                        input logic [15:0] imm, input logic [4:0] dst, input string tag);
    logic [31:0] er;
    logic ew, eo;
    model(op, a, b, imm, dst, er, ew, eo);
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; imm_i = imm; dst_i = dst;
    @(posedge clk_i);
    #1;
    checks++;
    if (result_o !== er || wr_en_o !== ew || ovf_o !== eo || wr_dst_o !== dst) begin
      errors++;
      $display("FAIL %s op=%0d: got res=%h we=%b ovf=%b dst=%0d exp res=%h we=%b ovf=%b dst=%0d R13",
               tag, op, result_o, wr_en_o, ovf_o, wr_dst_o, er, ew, eo, dst);
    end
  endtask

  function automatic logic [31:0] pick32();
    case ($urandom_range(0, 7))
      0: return 32'h7fffffff;
      1: return 32'h80000000;
      2: return 32'hffffffff;
      3: return 32'h0;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #200000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [4:0] rop;
    void'($urandom(32'd20251));
    repeat (3) @(posedge clk_i);
    #1;
    checks++;
    if (result_o !== '0 || wr_en_o !== 1'b0 || wr_dst_o !== '0 || ovf_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: got %h %b %0d %b exp 0 0 0 0", result_o, wr_en_o, wr_dst_o, ovf_o);
    end
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R3 trapping overflow boundaries
    run_op(5'd0, 32'h7fffffff, 32'h1, 16'h0, 5'd3, "R3");
    run_op(5'd0, 32'h80000000, 32'hffffffff, 16'h0, 5'd3, "R3");
    run_op(5'd0, 32'h7ffffffe, 32'h1, 16'h0, 5'd3, "R3");
    run_op(5'd2, 32'h80000000, 32'h1, 16'h0, 5'd4, "R3");
    run_op(5'd2, 32'h7fffffff, 32'hffffffff, 16'h0, 5'd4, "R3");
    run_op(5'd2, 32'h0, 32'h80000000, 16'h0, 5'd4, "R3");
    run_op(5'd10, 32'h7fff8000, 32'h0, 16'h7fff, 5'd5, "R3");
    run_op(5'd10, 32'h80000000, 32'h0, 16'hffff, 5'd5, "R3");
    // R4 wrapping forms
    run_op(5'd1, 32'h7fffffff, 32'h1, 16'h0, 5'd6, "R4");
    run_op(5'd3, 32'h80000000, 32'h1, 16'h0, 5'd6, "R4");
    run_op(5'd11, 32'h7fffffff, 32'h0, 16'h0001, 5'd6, "R4");
    // R5 NOR
    run_op(5'd7, 32'hf0f00000, 32'h0000f0f0, 16'h0, 5'd7, "R5");
    // R6 signed vs unsigned
    run_op(5'd8, 32'hffffffff, 32'h1, 16'h0, 5'd8, "R6");
    run_op(5'd9, 32'hffffffff, 32'h1, 16'h0, 5'd8, "R6");
    // R7 sign extension
    run_op(5'd12, 32'hfffffff0, 32'h0, 16'hfff8, 5'd9, "R7");
    run_op(5'd11, 32'h10, 32'h0, 16'hffff, 5'd9, "R7");
    // R8 unsigned compare with sign-extended immediate
    run_op(5'd13, 32'hfffffffe, 32'h0, 16'hffff, 5'd10, "R8");
    run_op(5'd13, 32'hffffffff, 32'h0, 16'hffff, 5'd10, "R8");
    // R9 zero extension
    run_op(5'd14, 32'hffffffff, 32'h0, 16'h8001, 5'd11, "R9");
    run_op(5'd15, 32'h0, 32'h0, 16'hffff, 5'd11, "R9");
    run_op(5'd16, 32'hffffffff, 32'h0, 16'h8000, 5'd11, "R9");
    // R10 load-upper
    run_op(5'd17, 32'hffffffff, 32'hffffffff, 16'habcd, 5'd12, "R10");
    // R11 register 0 destination
    run_op(5'd1, 32'h5, 32'h6, 16'h0, 5'd0, "R11");
    run_op(5'd17, 32'h0, 32'h0, 16'h1234, 5'd0, "R11");
    // R12 undefined codes
    run_op(5'd18, 32'h1, 32'h2, 16'h3, 5'd13, "R12");
    run_op(5'd31, 32'h7fffffff, 32'h1, 16'h7fff, 5'd13, "R12");

    // R2: output holds until the clock edge
    @(negedge clk_i);
    op_i = 5'd5; a_i = 32'h00ff0000; b_i = 32'h000000ff; dst_i = 5'd14;
    #1;
    checks++;
    if (result_o !== 32'h0 || wr_dst_o !== 5'd13) begin
      errors++;
      $display("FAIL R2 early change: got %h/%0d exp 00000000/13", result_o, wr_dst_o);
    end
    @(posedge clk_i);
    #1;
    checks++;
    if (result_o !== 32'h00ff00ff || wr_dst_o !== 5'd14) begin
      errors++;
      $display("FAIL R2 after edge: got %h/%0d exp 00ff00ff/14", result_o, wr_dst_o);
    end

    // Random mix
    for (int i = 0; i < 3000; i++) begin
      rop = 5'($urandom_range(0, 20));
      run_op(rop, pick32(), pick32(), 16'($urandom), 5'($urandom), tag_of(rop));
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule